// File: doc/BRIEF.md
# Multi-core mailbox interrupt controller

This block is the local interrupt controller of a four-core cluster. It holds sixteen 32-bit mailboxes, four for each core. One core signals another by writing bits into a mailbox through its set address. The receiving core acknowledges by writing the same bits to the matching clear address. A mailbox requests an interrupt for as long as any of its bits is 1.

Each core has one control register for its four timer lines and one for its four mailboxes. Each register gives every source an IRQ enable and an FIQ enable, and the FIQ enable wins when both are set. One external shared interrupt can be steered to the IRQ of one core and to the FIQ of one core. A per-core performance-monitor interrupt is gated by a set/clear enable mask.

Each core gets one IRQ output and one FIQ output. A plain single-cycle register bus gives access to the controls and to per-core pending-status words.

Top module: `mbox_intc`

## Requirements
- R1: A write to a mailbox set address (0x080 + 16·core + 4·mailbox) ORs the write data into that mailbox only. A read of either its set or its clear address returns the current contents.
- R2: A write to a mailbox clear address (0x0C0 + 16·core + 4·mailbox) clears exactly the mailbox bits that are 1 in the write data.
- R3: A mailbox's interrupt source is active in every cycle in which the mailbox holds a nonzero value, and inactive once it is zero.
- R4: In the mailbox control register of core n (0x050 + 4n), bits 3:0 are the IRQ enables and bits 7:4 the FIQ enables of mailboxes 0–3. A source whose FIQ enable is set goes only to FIQ.
- R5: The timer control register of core n (0x040 + 4n) uses the same layout for timer lines 0–3, also with FIQ taking priority. It reads back the written 8 bits.
- R6: The IRQ-pending word of core n (read at 0x060 + 4n) and the FIQ-pending word (read at 0x070 + 4n) show only enabled sources routed to that output. Bits 3:0 are the timer lines, bits 7:4 are mailboxes 0–3, bit 8 is the shared interrupt and bit 9 is the performance-monitor interrupt, which appears in the IRQ word only.
- R7: The routing register at 0x00C steers the shared interrupt. Bits 1:0 select the core whose IRQ it drives and bits 3:2 select the core whose FIQ it drives. The register reads back.
- R8: Writing 1 to bit n at 0x010 enables the performance-monitor interrupt of core n. Writing 1 to bit n at 0x014 disables it. Both addresses read back the enable mask.
- R9: irq_o[n] and fiq_o[n] are registered: each is the OR of the matching pending word, one cycle delayed. Each output goes low one cycle after its sources clear.
- R10: Writes to undefined addresses, to pending words or to unaligned addresses change no state. Reads from undefined or unaligned addresses return 0.
- R11: Reset (synchronous, active high) clears all mailboxes, enables, the monitor mask and both routing fields (core 0), and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| timer_irq_in | input | 16 | Timer lines; bit 4·core + line |
| shared_irq_in | input | 1 | External shared interrupt |
| pmu_irq_in | input | 4 | Performance-monitor interrupt per core |
| irq_o | output | 4 | IRQ request per core |
| fiq_o | output | 4 | FIQ request per core |

## Verification
On every cycle, the assertions check the following:
- set and clear writes land on the addressed mailbox;
- no timer or mailbox source is routed to IRQ and FIQ at once;
- the shared interrupt reaches at most one core's IRQ;
- the monitor mask follows set writes;
- the outputs follow their pending words with one cycle of delay;
- reset empties every mailbox.

Only the bench scenarios can show the rest:
- the exact address map and the bit positions in the pending words;
- read-back values;
- that a mailbox write leaves the other fifteen untouched;
- that ignored writes leave state unchanged.

// File: rtl/mbox_intc_pkg.sv
package mbox_intc_pkg;

    parameter int NCORE = 4;
    parameter int NMBX  = 4;
    parameter int NTMR  = 4;
    parameter int DW    = 32;
    parameter int AW    = 8;

    localparam int CW      = $clog2(NCORE);
    localparam int NBOX    = NCORE * NMBX;
    localparam int BW      = $clog2(NBOX);
    localparam int SH_BIT  = NTMR + NMBX;
    localparam int PMU_BIT = SH_BIT + 1;
    localparam int PEND_W  = PMU_BIT + 1;
    localparam int CTRL_W  = 2 * NMBX;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_ROUTE,
        ACC_PMU_SET,
        ACC_PMU_CLR,
        ACC_TMR,
        ACC_MBC,
        ACC_IRQP,
        ACC_FIQP,
        ACC_MB_SET,
        ACC_MB_CLR
    } acc_e;

    typedef struct packed {
        acc_e            kind;
        logic [CW-1:0]   core;
        logic [BW-1:0]   slot;
    } dec_t;

    typedef struct packed {
        logic [NMBX-1:0] fiq;
        logic [NMBX-1:0] irq;
    } split_t;

    typedef struct packed {
        logic [CW-1:0] fiq_core;
        logic [CW-1:0] irq_core;
    } shroute_t;

    // FIQ enable takes priority over IRQ enable for the same source
    function automatic split_t steer(input logic [NMBX-1:0] src,
                                     input logic [CTRL_W-1:0] ctrl);
        split_t s;
        s.fiq = src & ctrl[CTRL_W-1:NMBX];
        s.irq = src & ctrl[NMBX-1:0] & ~ctrl[CTRL_W-1:NMBX];
        return s;
    endfunction

    function automatic dec_t decode(input logic [AW-1:0] a);
        dec_t d;
        d.kind = ACC_NONE;
        d.core = a[2 +: CW];
        d.slot = a[2 +: BW];
        if (a[1:0] == 2'b00) begin
            case (a[7:4])
                4'h0: if (a[3:2] == 2'd3) d.kind = ACC_ROUTE;
                4'h1: begin
                    if (a[3:2] == 2'd0) d.kind = ACC_PMU_SET;
                    else if (a[3:2] == 2'd1) d.kind = ACC_PMU_CLR;
                end
                4'h4: d.kind = ACC_TMR;
                4'h5: d.kind = ACC_MBC;
                4'h6: d.kind = ACC_IRQP;
                4'h7: d.kind = ACC_FIQP;
                4'h8, 4'h9, 4'hA, 4'hB: d.kind = ACC_MB_SET;
                4'hC, 4'hD, 4'hE, 4'hF: d.kind = ACC_MB_CLR;
                default: d.kind = ACC_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_intc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NBOX-1:0]           set_hit,
    input  logic [NBOX-1:0]           clr_hit,
    input  logic [DW-1:0]             wdata,
    output logic [NBOX-1:0][DW-1:0]   box,
    output logic [NBOX-1:0]           busy
);

    for (genvar i = 0; i < NBOX; i++) begin : g_box
        always_ff @(posedge clk) begin
            if (rst)
                box[i] <= '0;
            else if (set_hit[i])
                box[i] <= box[i] | wdata;
            else if (clr_hit[i])
                box[i] <= box[i] & ~wdata;
        end

        assign busy[i] = |box[i];

        // R1
        set_lands_chk: assert property (@(posedge clk) disable iff (rst)
            set_hit[i] |=> ((box[i] & $past(wdata)) == $past(wdata)));

        // R2
        clr_lands_chk: assert property (@(posedge clk) disable iff (rst)
            clr_hit[i] |=> ((box[i] & $past(wdata)) == '0));

        // R11
        rst_empty_chk: assert property (@(posedge clk)
            rst |=> (box[i] == '0));
    end

endmodule

// File: rtl/core_irq_path.sv
module core_irq_path
    import mbox_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NTMR-1:0]   tmr_src,
    input  logic [NMBX-1:0]   mbx_busy,
    input  logic [CTRL_W-1:0] tmr_ctrl,
    input  logic [CTRL_W-1:0] mbx_ctrl,
    input  logic              sh_irq,
    input  logic              sh_fiq,
    input  logic              pmu_act,
    output logic [PEND_W-1:0] irq_pend,
    output logic [PEND_W-1:0] fiq_pend,
    output logic              irq_o,
    output logic              fiq_o
);

    split_t ts, ms;

    always_comb begin
        ts       = steer(tmr_src, tmr_ctrl);
        ms       = steer(mbx_busy, mbx_ctrl);
        irq_pend = {pmu_act, sh_irq, ms.irq, ts.irq};
        fiq_pend = {1'b0,    sh_fiq, ms.fiq, ts.fiq};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |irq_pend;
            fiq_o <= |fiq_pend;
        end
    end

    // R4 R5
    no_dual_route_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_pend[SH_BIT-1:0] & fiq_pend[SH_BIT-1:0]) == '0));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_pend) |=> irq_o);

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !(|irq_pend) |=> !irq_o);

    // R9
    fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|fiq_pend) |=> fiq_o);

endmodule

// File: rtl/mbox_intc.sv
module mbox_intc
    import mbox_intc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    input  logic [NCORE*NTMR-1:0]  timer_irq_in,
    input  logic                   shared_irq_in,
    input  logic [NCORE-1:0]       pmu_irq_in,
    output logic [NCORE-1:0]       irq_o,
    output logic [NCORE-1:0]       fiq_o
);

    dec_t                         dec;
    logic [NCORE-1:0][CTRL_W-1:0] tmr_ctrl;
    logic [NCORE-1:0][CTRL_W-1:0] mbx_ctrl;
    shroute_t                     route;
    logic [NCORE-1:0]             pmu_en;
    logic [NBOX-1:0]              set_hit, clr_hit;
    logic [NBOX-1:0][DW-1:0]      box;
    logic [NBOX-1:0]              busy;
    logic [NCORE-1:0][PEND_W-1:0] irq_pend, fiq_pend;
    logic [NCORE-1:0]             sh_irq_v;

    assign dec = decode(bus_addr);

    always_comb begin
        set_hit = '0;
        clr_hit = '0;
        if (bus_wr && dec.kind == ACC_MB_SET) set_hit[dec.slot] = 1'b1;
        if (bus_wr && dec.kind == ACC_MB_CLR) clr_hit[dec.slot] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_ctrl <= '0;
            mbx_ctrl <= '0;
            route    <= '0;
            pmu_en   <= '0;
        end else if (bus_wr) begin
            case (dec.kind)
                ACC_ROUTE:   route <= bus_wdata[2*CW-1:0];
                ACC_PMU_SET: pmu_en <= pmu_en | bus_wdata[NCORE-1:0];
                ACC_PMU_CLR: pmu_en <= pmu_en & ~bus_wdata[NCORE-1:0];
                ACC_TMR:     tmr_ctrl[dec.core] <= bus_wdata[CTRL_W-1:0];
                ACC_MBC:     mbx_ctrl[dec.core] <= bus_wdata[CTRL_W-1:0];
                default:     ;
            endcase
        end
    end

    mbox_store u_store (
        .clk     (clk),
        .rst     (rst),
        .set_hit (set_hit),
        .clr_hit (clr_hit),
        .wdata   (bus_wdata),
        .box     (box),
        .busy    (busy)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assign sh_irq_v[c] = shared_irq_in && (route.irq_core == CW'(c));

        core_irq_path u_path (
            .clk      (clk),
            .rst      (rst),
            .tmr_src  (timer_irq_in[c*NTMR +: NTMR]),
            .mbx_busy (busy[c*NMBX +: NMBX]),
            .tmr_ctrl (tmr_ctrl[c]),
            .mbx_ctrl (mbx_ctrl[c]),
            .sh_irq   (sh_irq_v[c]),
            .sh_fiq   (shared_irq_in && (route.fiq_core == CW'(c))),
            .pmu_act  (pmu_irq_in[c] && pmu_en[c]),
            .irq_pend (irq_pend[c]),
            .fiq_pend (fiq_pend[c]),
            .irq_o    (irq_o[c]),
            .fiq_o    (fiq_o[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (dec.kind)
            ACC_ROUTE:   bus_rdata[2*CW-1:0]   = route;
            ACC_PMU_SET,
            ACC_PMU_CLR: bus_rdata[NCORE-1:0]  = pmu_en;
            ACC_TMR:     bus_rdata[CTRL_W-1:0] = tmr_ctrl[dec.core];
            ACC_MBC:     bus_rdata[CTRL_W-1:0] = mbx_ctrl[dec.core];
            ACC_IRQP:    bus_rdata[PEND_W-1:0] = irq_pend[dec.core];
            ACC_FIQP:    bus_rdata[PEND_W-1:0] = fiq_pend[dec.core];
            ACC_MB_SET,
            ACC_MB_CLR:  bus_rdata = box[dec.slot];
            default:     bus_rdata = '0;
        endcase
    end

    // R7
    shared_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sh_irq_v));

    // R8
    pmu_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.kind == ACC_PMU_SET) |=>
            ((pmu_en & $past(bus_wdata[NCORE-1:0])) == $past(bus_wdata[NCORE-1:0])));

    // R11
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq_o == '0 && fiq_o == '0 && pmu_en == '0));

endmodule

// File: tb/mbox_intc_tb.sv
module mbox_intc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] timer_irq_in = '0;
    logic        shared_irq_in = 1'b0;
    logic [3:0]  pmu_irq_in = '0;
    logic [3:0]  irq_o, fiq_o;

    int total = 0;
    int bad = 0;
    bit chk_valid = 1'b0;
    bit done = 1'b0;

    bit          q_out[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    mbox_intc u_dut (
        .clk           (clk),
        .rst           (rst),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .timer_irq_in  (timer_irq_in),
        .shared_irq_in (shared_irq_in),
        .pmu_irq_in    (pmu_irq_in),
        .irq_o         (irq_o),
        .fiq_o         (fiq_o)
    );

    // monitor: samples 2 ns after the falling edge, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (chk_valid && q_exp.size() > 0) begin
                bit          o;
                logic [31:0] e, a;
                string       t;
                o = q_out.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = o ? {24'd0, fiq_o, irq_o} : bus_rdata;
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0;
        chk_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        chk_valid = 1'b0;
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = a;
        q_out.push_back(1'b0);
        q_exp.push_back(e);
        q_tag.push_back(t);
        chk_valid = 1'b1;
    endtask

    // expected {fiq_o, irq_o}
    task automatic outs(input logic [7:0] e, input string t);
        @(negedge clk);
        bus_wr = 1'b0;
        q_out.push_back(1'b1);
        q_exp.push_back({24'd0, e});
        q_tag.push_back(t);
        chk_valid = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        rd(8'h80, 32'h0, "R11 mailbox after reset");
        rd(8'h0C, 32'h0, "R11 routing after reset");
        outs(8'h00, "R11 outputs after reset");

        // R1 OR-accumulation, readable at both addresses
        wr(8'h80, 32'h0000_00F0);
        wr(8'h80, 32'h0000_0F00);
        rd(8'h80, 32'h0000_0FF0, "R1 set ORs data");
        rd(8'hC0, 32'h0000_0FF0, "R1 read via clear address");

        // R2 bitwise clear
        wr(8'hC0, 32'h0000_0030);
        rd(8'h80, 32'h0000_0FC0, "R2 clear removes only written ones");

        // R3 R6 R9 mailbox 0 of core 0 to IRQ
        wr(8'h50, 32'h01);
        rd(8'h60, 32'h10, "R3 R6 irq pending mailbox0 bit4");
        rd(8'h70, 32'h0, "R6 fiq pending empty");
        outs(8'h01, "R9 irq core0 high");
        wr(8'hC0, 32'hFFFF_FFFF);
        outs(8'h01, "R9 irq still high one cycle after clear");
        outs(8'h00, "R3 R9 irq low after mailbox empties");
        rd(8'h60, 32'h0, "R3 pending gone");

        // R4 FIQ overrides IRQ, core1 mailbox2
        wr(8'h54, 32'h44);
        wr(8'h98, 32'h1);
        rd(8'h74, 32'h40, "R4 fiq pending mailbox2");
        rd(8'h64, 32'h0, "R4 irq suppressed by fiq enable");
        outs(8'h20, "R4 fiq core1 high");
        wr(8'hD8, 32'h1);
        wr(8'h54, 32'h04);
        wr(8'h98, 32'h8000_0000);
        rd(8'h64, 32'h40, "R4 irq-only route");
        outs(8'h02, "R4 irq core1 high");
        wr(8'hD8, 32'h8000_0000);

        // R5 timer line 1 of core 2
        @(negedge clk);
        bus_wr = 1'b0;
        timer_irq_in[9] = 1'b1;
        timer_irq_in[12] = 1'b1;
        wr(8'h48, 32'h02);
        rd(8'h68, 32'h02, "R5 timer irq route");
        wr(8'h48, 32'h22);
        rd(8'h78, 32'h02, "R5 timer fiq route");
        rd(8'h68, 32'h0, "R5 fiq overrides irq");
        rd(8'h48, 32'h22, "R5 control read back");
        rd(8'h6C, 32'h0, "R6 disabled timer not pending");
        @(negedge clk);
        timer_irq_in = '0;

        // R7 shared: irq to core3, fiq to core2
        wr(8'h0C, 32'hB);
        @(negedge clk);
        bus_wr = 1'b0;
        shared_irq_in = 1'b1;
        rd(8'h6C, 32'h100, "R7 shared irq core3");
        rd(8'h78, 32'h100, "R7 shared fiq core2");
        rd(8'h60, 32'h0, "R7 shared not on core0");
        outs(8'h48, "R7 outputs");
        rd(8'h0C, 32'hB, "R7 routing read back");
        @(negedge clk);
        shared_irq_in = 1'b0;

        // R8 monitor enables
        pmu_irq_in = 4'hF;
        wr(8'h10, 32'h5);
        rd(8'h10, 32'h5, "R8 set mask");
        rd(8'h68, 32'h200, "R8 pmu pending core2");
        rd(8'h64, 32'h0, "R8 pmu masked core1");
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h4, "R8 clear mask");
        rd(8'h60, 32'h0, "R8 core0 disabled");
        outs(8'h04, "R8 irq core2 only");
        @(negedge clk);
        pmu_irq_in = '0;

        // R10 ignored writes, zero reads
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h60, 32'hFFFF);
        wr(8'h81, 32'hFF);
        wr(8'h3C, 32'hFF);
        rd(8'h80, 32'h0, "R10 unaligned write ignored");
        rd(8'h60, 32'h0, "R10 pending write ignored");
        rd(8'h50, 32'h01, "R10 control unchanged");
        rd(8'h00, 32'h0, "R10 undefined read zero");
        rd(8'h81, 32'h0, "R10 unaligned read zero");
        rd(8'h3C, 32'h0, "R10 undefined read zero 2");

        // R1 mailbox isolation
        wr(8'hBC, 32'h1234);
        rd(8'hFC, 32'h1234, "R1 core3 mailbox3");
        rd(8'h80, 32'h0, "R1 other mailbox untouched");
        rd(8'hAC, 32'h0, "R1 neighbour untouched");

        idle();
        idle();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule